// File: doc/BRIEF.md
# Phase-Continuous NCO I/Q Renderer

The renderer produces one signed I/Q output pair for each nanosecond of a pulse. A single-cycle sample strobe marks each nanosecond of the real-time timeline. While the pulse-active level is high, every strobe reads one I sample and one Q sample from external waveform storage. The pair is rotated by the current oscillator phase, scaled by the committed per-path gain, shifted by the committed per-path offset, saturated, and presented one clock later with a valid flag.

The 32-bit phase accumulator advances by the committed frequency word on every strobe, whether or not a pulse is playing. Phase therefore stays coherent across idle gaps, acquisitions and any other timed interval. A clear strobe zeroes the accumulator.

Frequency, phase offset, gain and offset arrive already committed by the surrounding sequencer. The block applies them as they stand on each strobe. Waveform storage lives outside the block: the block publishes the two waveform selectors and the position within the pulse, and the storage returns the two samples combinationally in the same cycle.

Top module: `nco_iq_renderer`

## Requirements
- R1: After reset, smp_i_o and smp_q_o are zero, out_vld_o is low, rd_pos_o is zero, and the phase accumulator is zero.
- R2: On every cycle with tick_i high, the accumulator becomes (accumulator + freq_i) mod 2^32, whether play_i is high or low. On cycles with tick_i low and phase_clr_i low, the accumulator holds its value.
- R3: While phase_clr_i is high, the accumulator reads as zero for that cycle. The sample taken in that cycle uses accumulator zero, and afterwards the accumulator equals freq_i if tick_i was high and zero otherwise.
- R4: The lookup angle is p = bits [31:26] of (accumulator + phase_i). sine(p) = round(32767*sin(2*pi*p/64)), rounding half away from zero, and cosine(p) = sine((p+16) mod 64).
- R5: With waveform samples wi and wq, ri = floor((wi*cos - wq*sin)/2^15) and rq = floor((wi*sin + wq*cos)/2^15).
- R6: The output is sat16(floor(r*gain/2^15) + offset) per path, with gain_i_i/offs_i_i on I and gain_q_i/offs_q_i on Q. sat16 clamps to the range [-32768, 32767].
- R7: A cycle with tick_i and play_i both high makes out_vld_o high in the next cycle, carrying that sample, so N such ticks give exactly N valid pairs. In every other cycle out_vld_o is low and both outputs are zero.
- R8: rd_pos_o counts the ticks of the current pulse from 0. It increments on each tick with play_i high, returns to 0 on a tick with play_i low, and holds on cycles without a tick.
- R9: The waveform selectors are taken from wav_sel_i_i/wav_sel_q_i on the first tick of a pulse (rd_pos_o = 0) and shown on rd_sel_i_o/rd_sel_q_o. For the rest of the pulse, changes on the selector inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-nanosecond sample strobe |
| play_i | input | 1 | Pulse active |
| phase_clr_i | input | 1 | Zero the phase accumulator |
| freq_i | input | 32 | Committed frequency word per tick |
| phase_i | input | 32 | Committed phase offset |
| gain_i_i | input | 16 | Committed I gain, signed |
| gain_q_i | input | 16 | Committed Q gain, signed |
| offs_i_i | input | 16 | Committed I offset, signed |
| offs_q_i | input | 16 | Committed Q offset, signed |
| wav_sel_i_i | input | 4 | Waveform index for the I path |
| wav_sel_q_i | input | 4 | Waveform index for the Q path |
| rd_sel_i_o | output | 4 | Storage read select, I path |
| rd_sel_q_o | output | 4 | Storage read select, Q path |
| rd_pos_o | output | 16 | Storage read position within the pulse |
| rd_dat_i_i | input | 16 | I waveform sample, signed |
| rd_dat_q_i | input | 16 | Q waveform sample, signed |
| smp_i_o | output | 16 | I output sample, signed |
| smp_q_o | output | 16 | Q output sample, signed |
| out_vld_o | output | 1 | Output pair valid |

## Verification
The assertions assume that the sequencer drives every control input from reset onward and that no pulse reaches 65536 ticks, so the position counter never wraps back to zero inside a pulse. The stimulus drives all inputs from time zero, changes them only on falling edges, and keeps every pulse below 80 ticks. It also mixes clock cycles without a tick into active pulses and idle gaps, so the hold conditions are exercised as well as the advance conditions.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  localparam int LUT_KW   = 4;            // quarter-wave address bits
  localparam int LUT_SELW = LUT_KW + 2;   // full-turn angle bits
  localparam int LUT_QN   = 1 << LUT_KW;  // steps per quarter turn

  // round(32767*sin(pi*k/32)), k = 0..16
  function automatic logic [15:0] qsin_mag(input logic [LUT_KW:0] k);
    case (k)
      5'd0:  return 16'd0;
      5'd1:  return 16'd3212;
      5'd2:  return 16'd6393;
      5'd3:  return 16'd9512;
      5'd4:  return 16'd12539;
      5'd5:  return 16'd15446;
      5'd6:  return 16'd18204;
      5'd7:  return 16'd20787;
      5'd8:  return 16'd23170;
      5'd9:  return 16'd25329;
      5'd10: return 16'd27245;
      5'd11: return 16'd28898;
      5'd12: return 16'd30273;
      5'd13: return 16'd31356;
      5'd14: return 16'd32137;
      5'd15: return 16'd32609;
      default: return 16'd32767;
    endcase
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc #(
  parameter int PHW = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           clr_i,
  input  logic [PHW-1:0] freq_i,
  output logic [PHW-1:0] phase_o
);
  logic [PHW-1:0] acc_q;

  // cleared value is visible in the same cycle
  assign phase_o = clr_i ? '0 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (tick_i) acc_q <= phase_o + freq_i;
    else             acc_q <= phase_o;
  end

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(acc_q)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tick_i) |=> (acc_q == '0)); // R3
endmodule

// File: rtl/nco_quarter_lut.sv
`timescale 1ns/1ps
module nco_quarter_lut
  import nco_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [LUT_SELW-1:0] sel_i,
  output logic signed [DW-1:0] val_o
);
  logic [1:0]          quad;
  logic [LUT_KW:0]     k;
  logic signed [DW-1:0] mag;

  always_comb begin
    quad = sel_i[LUT_SELW-1 -: 2];
    k    = {1'b0, sel_i[LUT_KW-1:0]};
    if (quad[0]) k = (LUT_KW+1)'(LUT_QN) - k;   // mirror odd quadrants
    mag   = DW'(qsin_mag(k));
    val_o = quad[1] ? -mag : mag;               // negate lower half-turn
  end
endmodule

// File: rtl/iq_rotate_scale.sv
`timescale 1ns/1ps
module iq_rotate_scale #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] wi_i,
  input  logic signed [DW-1:0] wq_i,
  input  logic signed [DW-1:0] sin_i,
  input  logic signed [DW-1:0] cos_i,
  input  logic signed [DW-1:0] gain_i_i,
  input  logic signed [DW-1:0] gain_q_i,
  input  logic signed [DW-1:0] offs_i_i,
  input  logic signed [DW-1:0] offs_q_i,
  output logic signed [DW-1:0] yi_o,
  output logic signed [DW-1:0] yq_o
);
  localparam int RW = 2*DW + 2;
  localparam int SW = 3*DW + 3;
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [RW-1:0] rot_i, rot_q;

  function automatic logic signed [DW-1:0] lane(input logic signed [RW-1:0] r,
                                                input logic signed [DW-1:0] g,
                                                input logic signed [DW-1:0] o);
    logic signed [SW-1:0] t;
    t = (SW'(r) * SW'(g)) >>> (DW-1);
    t = t + SW'(o);
    if (t > SW'(MAXV))      return MAXV;
    else if (t < SW'(MINV)) return MINV;
    else                    return DW'(t);
  endfunction

  always_comb begin
    rot_i = (RW'(wi_i) * RW'(cos_i) - RW'(wq_i) * RW'(sin_i)) >>> (DW-1);
    rot_q = (RW'(wi_i) * RW'(sin_i) + RW'(wq_i) * RW'(cos_i)) >>> (DW-1);
    yi_o  = lane(rot_i, gain_i_i, offs_i_i);
    yq_o  = lane(rot_q, gain_q_i, offs_q_i);
  end
endmodule

// File: rtl/nco_iq_renderer.sv
`timescale 1ns/1ps
module nco_iq_renderer
  import nco_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PHW  = 32,
  parameter int IW   = 4,
  parameter int POSW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 play_i,
  input  logic                 phase_clr_i,
  input  logic [PHW-1:0]       freq_i,
  input  logic [PHW-1:0]       phase_i,
  input  logic signed [DW-1:0] gain_i_i,
  input  logic signed [DW-1:0] gain_q_i,
  input  logic signed [DW-1:0] offs_i_i,
  input  logic signed [DW-1:0] offs_q_i,
  input  logic [IW-1:0]        wav_sel_i_i,
  input  logic [IW-1:0]        wav_sel_q_i,
  output logic [IW-1:0]        rd_sel_i_o,
  output logic [IW-1:0]        rd_sel_q_o,
  output logic [POSW-1:0]      rd_pos_o,
  input  logic signed [DW-1:0] rd_dat_i_i,
  input  logic signed [DW-1:0] rd_dat_q_i,
  output logic signed [DW-1:0] smp_i_o,
  output logic signed [DW-1:0] smp_q_o,
  output logic                 out_vld_o
);
  logic [PHW-1:0]       phase_acc, phase_sum;
  logic [LUT_SELW-1:0]  lut_sel [2];
  logic signed [DW-1:0] trig [2];   // [0] sine, [1] cosine
  logic signed [DW-1:0] y_i, y_q;
  logic [POSW-1:0]      pos_q;
  logic [IW-1:0]        sel_i_q, sel_q_q;
  logic                 fire;

  assign fire = tick_i && play_i;

  nco_phase_acc #(.PHW(PHW)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (phase_clr_i),
    .freq_i (freq_i),
    .phase_o(phase_acc)
  );

  always_comb begin
    phase_sum  = phase_acc + phase_i;
    lut_sel[0] = phase_sum[PHW-1 -: LUT_SELW];
    lut_sel[1] = lut_sel[0] + LUT_SELW'(LUT_QN);  // quarter turn ahead
  end

  for (genvar g = 0; g < 2; g++) begin : g_trig
    nco_quarter_lut #(.DW(DW)) u_lut (
      .sel_i(lut_sel[g]),
      .val_o(trig[g])
    );
  end

  iq_rotate_scale #(.DW(DW)) u_rot (
    .wi_i    (rd_dat_i_i),
    .wq_i    (rd_dat_q_i),
    .sin_i   (trig[0]),
    .cos_i   (trig[1]),
    .gain_i_i(gain_i_i),
    .gain_q_i(gain_q_i),
    .offs_i_i(offs_i_i),
    .offs_q_i(offs_q_i),
    .yi_o    (y_i),
    .yq_o    (y_q)
  );

  // selectors pass through on the first tick, then stay latched
  assign rd_pos_o   = pos_q;
  assign rd_sel_i_o = (pos_q == '0) ? wav_sel_i_i : sel_i_q;
  assign rd_sel_q_o = (pos_q == '0) ? wav_sel_q_i : sel_q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      sel_i_q <= '0;
      sel_q_q <= '0;
    end else if (fire) begin
      pos_q <= pos_q + 1'b1;
      if (pos_q == '0) begin
        sel_i_q <= wav_sel_i_i;
        sel_q_q <= wav_sel_q_i;
      end
    end else if (tick_i) begin
      pos_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o <= 1'b0;
      smp_i_o   <= '0;
      smp_q_o   <= '0;
    end else begin
      out_vld_o <= fire;
      smp_i_o   <= fire ? y_i : '0;
      smp_q_o   <= fire ? y_q : '0;
    end
  end

  AST_VLD_FROM_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> $past(tick_i && play_i)); // R7
  AST_POS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !play_i) |=> (rd_pos_o == '0)); // R8
  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(rd_pos_o)); // R8
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (rd_pos_o == '0 ||
              (rd_sel_i_o == $past(rd_sel_i_o) && rd_sel_q_o == $past(rd_sel_q_o)))); // R9
endmodule

// File: tb/nco_iq_renderer_tb.sv
`timescale 1ns/1ps
module nco_iq_renderer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, play = 1'b0, clr = 1'b0;
  logic [31:0] fq = '0, ph = '0;
  logic signed [15:0] gi = '0, gq = '0, oi = '0, oq = '0;
  logic [3:0] wsel_i = '0, wsel_q = '0;
  logic [3:0] rd_sel_i_o, rd_sel_q_o;
  logic [15:0] rd_pos_o;
  logic signed [15:0] rd_dat_i, rd_dat_q, smp_i_o, smp_q_o;
  logic out_vld_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] m_acc = '0;
  int m_pos = 0, m_si = 0, m_sq = 0;

  always #2.5 clk = ~clk;

  // waveform storage model: 15 = +full scale, 14 = -full scale
  function automatic int wav(int idx, int pos);
    if (idx == 15) return 32767;
    if (idx == 14) return -32768;
    return ((idx * 7919 + pos * 1237) % 40001) - 20000;
  endfunction

  assign rd_dat_i = 16'(wav(int'(rd_sel_i_o), int'(rd_pos_o)));
  assign rd_dat_q = 16'(wav(int'(rd_sel_q_o), int'(rd_pos_o)));

  nco_iq_renderer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .play_i(play), .phase_clr_i(clr),
    .freq_i(fq), .phase_i(ph), .gain_i_i(gi), .gain_q_i(gq), .offs_i_i(oi), .offs_q_i(oq),
    .wav_sel_i_i(wsel_i), .wav_sel_q_i(wsel_q), .rd_sel_i_o(rd_sel_i_o), .rd_sel_q_o(rd_sel_q_o),
    .rd_pos_o(rd_pos_o), .rd_dat_i_i(rd_dat_i), .rd_dat_q_i(rd_dat_q),
    .smp_i_o(smp_i_o), .smp_q_o(smp_q_o), .out_vld_o(out_vld_o)
  );

  function automatic longint trg(int p);
    real s;
    s = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(p % 64) / 64.0);
    if (s >= 0.0) return longint'($rtoi(s + 0.5));
    return -longint'($rtoi(-s + 0.5));
  endfunction

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock cycle: drive, model, check at the next falling edge
  task automatic step(bit tk, bit pl, bit cl, string req);
    longint wi, wq, s, c, ri, rq, ei, eq;
    int si, sq, p;
    logic [31:0] eff, pe;
    bit ev;
    tick = tk; play = pl; clr = cl;
    si = m_si; sq = m_sq; ei = 0; eq = 0;
    #1;
    chk("R8", "rd_pos", longint'(rd_pos_o), longint'(m_pos));
    eff = cl ? 32'd0 : m_acc;
    ev = tk && pl;
    if (ev) begin
      if (m_pos == 0) begin si = int'(wsel_i); sq = int'(wsel_q); end
      chk("R9", "rd_sel_i", longint'(rd_sel_i_o), longint'(si));
      chk("R9", "rd_sel_q", longint'(rd_sel_q_o), longint'(sq));
      pe = eff + ph;
      p  = int'(pe[31:26]);
      s  = trg(p);
      c  = trg((p + 16) % 64);
      wi = longint'(wav(si, m_pos));
      wq = longint'(wav(sq, m_pos));
      ri = (wi * c - wq * s) >>> 15;
      rq = (wi * s + wq * c) >>> 15;
      ei = sat16(((ri * longint'(gi)) >>> 15) + longint'(oi));
      eq = sat16(((rq * longint'(gq)) >>> 15) + longint'(oq));
    end
    @(posedge clk);
    m_acc = tk ? eff + fq : eff;
    if (tk) begin
      if (pl) begin
        if (m_pos == 0) begin m_si = si; m_sq = sq; end
        m_pos++;
      end else m_pos = 0;
    end
    @(negedge clk);
    chk(req, "vld", longint'(out_vld_o), longint'(ev));
    chk(req, "smp_i", longint'(smp_i_o), ei);
    chk(req, "smp_q", longint'(smp_q_o), eq);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_acc = '0; m_pos = 0;
    #1;
    chk("R1", "vld", longint'(out_vld_o), 0);
    chk("R1", "smp_i", longint'(smp_i_o), 0);
    chk("R1", "smp_q", longint'(smp_q_o), 0);
    chk("R1", "rd_pos", longint'(rd_pos_o), 0);
    @(negedge clk);
    // first sample must use a zero accumulator
    fq = 32'h0800_0000; ph = '0; gi = 16'sd32767; gq = 16'sd32767; oi = '0; oq = '0;
    wsel_i = 4'd1; wsel_q = 4'd2;
    step(1, 1, 0, "R1");
    step(1, 0, 0, "R1");
  endtask

  task automatic t_plain();
    fq = '0; ph = '0; gi = 16'sd32767; gq = 16'sd32767; oi = '0; oq = '0;
    wsel_i = 4'd3; wsel_q = 4'd5;
    for (int k = 0; k < 8; k++) step(1, 1, 0, "R7");
    step(1, 0, 0, "R7");
    step(0, 0, 0, "R7");
  endtask

  task automatic t_rotate();
    fq = 32'h0400_0000; ph = 32'h1000_0000;
    gi = 16'sd20000; gq = -16'sd15000; oi = 16'sd100; oq = -16'sd200;
    wsel_i = 4'd7; wsel_q = 4'd9;
    for (int k = 0; k < 70; k++) step(1, 1, 0, "R4");
    step(1, 0, 0, "R5");
  endtask

  task automatic t_coherence();
    fq = 32'h0123_4567; ph = 32'h0;
    gi = 16'sd30000; gq = 16'sd25000; oi = '0; oq = '0;
    wsel_i = 4'd4; wsel_q = 4'd6;
    for (int k = 0; k < 5; k++) step(1, 1, 0, "R2");
    for (int k = 0; k < 9; k++) step(1, 0, 0, "R2");
    fq = 32'h0345_6789;
    for (int k = 0; k < 4; k++) step(1, 0, 0, "R2");
    step(0, 0, 0, "R2");
    for (int k = 0; k < 6; k++) begin
      step(1, 1, 0, "R2");
      step(0, 1, 0, "R7");
    end
    step(1, 0, 0, "R8");
  endtask

  task automatic t_clear();
    fq = 32'h0555_0000; ph = 32'h2000_0000;
    gi = 16'sd32767; gq = 16'sd32767; oi = '0; oq = '0;
    wsel_i = 4'd8; wsel_q = 4'd10;
    for (int k = 0; k < 3; k++) step(1, 0, 0, "R2");
    step(0, 0, 1, "R3");
    step(1, 1, 0, "R3");
    step(1, 1, 0, "R3");
    step(1, 1, 1, "R3");
    step(1, 1, 0, "R3");
    step(1, 0, 0, "R3");
  endtask

  task automatic t_sat();
    fq = '0; ph = '0;
    gi = 16'sd32767; gq = 16'sd32767; oi = 16'sd32767; oq = -16'sd32768;
    wsel_i = 4'd15; wsel_q = 4'd14;
    for (int k = 0; k < 3; k++) step(1, 1, 0, "R6");
    step(1, 0, 0, "R6");
    gi = -16'sd32768; oi = -16'sd32768; gq = -16'sd32768; oq = 16'sd32767;
    for (int k = 0; k < 3; k++) step(1, 1, 0, "R6");
    step(1, 0, 0, "R6");
  endtask

  task automatic t_sel();
    fq = 32'h0200_0000; ph = 32'h0;
    gi = 16'sd32767; gq = 16'sd32767; oi = 16'sd5; oq = 16'sd7;
    wsel_i = 4'd2; wsel_q = 4'd6;
    step(1, 1, 0, "R9");
    wsel_i = 4'd9; wsel_q = 4'd11;
    for (int k = 0; k < 5; k++) step(1, 1, 0, "R9");
    step(1, 0, 0, "R9");
    step(1, 1, 0, "R9");
    step(1, 0, 0, "R9");
  endtask

  initial begin
    #(5 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_rotate();
    t_coherence();
    t_clear();
    t_sat();
    t_sel();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule